// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it compares the two source register numbers of the instruction in execute against the destinations held in the execute/memory and memory/writeback pipeline registers. From these comparisons it drives the select of each ALU operand multiplexer, so that a result that has not yet reached the register file still reaches the instruction that needs it.

A load cannot supply its data in time for the instruction directly behind it. The unit detects that pair while the consumer is still in decode. It then freezes the program counter and the decode register for one cycle and sends an empty slot into execute. That slot moves down the pipe with its register-file and data-memory write enables cleared, so it changes no architectural state. After the bubble, the loaded value reaches the consumer on the writeback bypass path. A small model of the pipeline registers is included so that the selects drive real operand multiplexers. The ALU, the memories and the register file stay outside the block: their values arrive on input ports. The register file is assumed to write in the first half of the cycle and read in the second half, so a producer three slots older than its consumer needs no bypass.

Top module: `fwd_interlock_unit`

## Requirements
- R1: When a source of the instruction in execute equals the destination of the execute/memory stage, that stage has its register write enable set and the destination is not register 0, the operand takes the execute/memory ALU result and its select reads 2'b10.
- R2: When only the memory/writeback stage holds such a match, the operand takes that stage's write data, which is the loaded word for a load, and its select reads 2'b01.
- R3: With no qualifying match, the operand is the register-file value captured at decode and its select reads 2'b00. This covers a producer three or more slots older than its consumer. Both sources of every instruction are always compared.
- R4: When a load with its write enable set sits in execute and its nonzero destination equals either source of the instruction in decode, stallFetch and bubbleInsert are high for exactly one cycle. One cycle later the consumer enters execute and receives the loaded word on the 2'b01 path.
- R5: The bubble carries no register write and no memory write, so wbWe and memWeOut pulse only for real instructions.
- R6: Register 0 is never a bypass source and never causes a stall.
- R7: When both stages match the same source, the execute/memory value (the younger producer) is selected.
- R8: After reset pcOut starts at 0 and rises by one each cycle. During a stall, pcOut and the decode register hold their values.
- R9: A producer with its register write enable clear is never bypassed and never causes a stall.
- R10: During reset pcOut is 0, both selects are 2'b00, and stallFetch, wbWe and memWeOut are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fetchRs1 | input | AW | First source register of the fetched instruction |
| fetchRs2 | input | AW | Second source register of the fetched instruction |
| fetchRd | input | AW | Destination register of the fetched instruction |
| fetchRegWe | input | 1 | Fetched instruction writes the register file |
| fetchMemRd | input | 1 | Fetched instruction is a load |
| fetchMemWe | input | 1 | Fetched instruction is a store |
| pcOut | output | PC_W | Word index of the instruction to fetch |
| rfData1 | input | DW | Register-file value for the first source of the decode instruction |
| rfData2 | input | DW | Register-file value for the second source of the decode instruction |
| exAluResult | input | DW | ALU result of the instruction in execute |
| memRdData | input | DW | Data-memory read word of the instruction in memory |
| aluOpA | output | DW | First ALU operand after bypass |
| aluOpB | output | DW | Second ALU operand after bypass |
| fwdSelA | output | 2 | Select of operand A: 00 register file, 01 writeback, 10 memory stage |
| fwdSelB | output | 2 | Select of operand B, same encoding |
| stallFetch | output | 1 | Holds the program counter and the decode register |
| bubbleInsert | output | 1 | Loads an empty slot into execute |
| memWeOut | output | 1 | Data-memory write enable of the memory stage |
| wbWe | output | 1 | Register-file write enable of the writeback stage |
| wbRd | output | AW | Register written at writeback |
| wbData | output | DW | Data written at writeback |

## Verification
On every cycle the assertions check several invariants. A stall never lasts two cycles. A slot loaded after a stall has both write enables clear. The front end keeps its state while stalled. Register 0 never shows up as a bypass source, and a writeback select is never chosen while the memory stage also matches. Only the bench scenarios can show that the correct value arrives: the right producer's data at the right distance, the loaded word after the bubble, and the operand falling back to the register file once the producer is three slots old. The bench sweeps every producer kind, destination, gap and source pair in a four-register configuration for this purpose. The count of write pulses around a load-use pair shows that the bubble stays silent at the pipeline ports.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opSrcE;

  typedef struct packed {
    logic                       holdFront;
    logic                       injectBubble;
    opSrcE [NUM_SRC-1:0]        opSel;
  } ctrlStrobesT;
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] srcReg,
  input  logic [AW-1:0] exMemRd,
  input  logic          exMemRegWe,
  input  logic [AW-1:0] memWbRd,
  input  logic          memWbRegWe,
  output opSrcE         sel
);
  logic memHit;
  logic wbHit;

  // A producer qualifies only with its write enable set and a nonzero target.
  assign memHit = exMemRegWe && (exMemRd != '0) && (exMemRd == srcReg);
  assign wbHit  = memWbRegWe && (memWbRd != '0) && (memWbRd == srcReg);

  always_comb begin
    if (memHit)     sel = SRC_MEM;  // younger producer first
    else if (wbHit) sel = SRC_WB;
    else            sel = SRC_RF;
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [AW-1:0]              ifIdRs1,
  input  logic [AW-1:0]              ifIdRs2,
  input  logic [NUM_SRC-1:0][AW-1:0] idExRs,
  input  logic [AW-1:0]              idExRd,
  input  logic                       idExRegWe,
  input  logic                       idExMemRd,
  input  logic [AW-1:0]              exMemRd,
  input  logic                       exMemRegWe,
  input  logic [AW-1:0]              memWbRd,
  input  logic                       memWbRegWe,
  output ctrlStrobesT                strobes
);
  opSrcE [NUM_SRC-1:0] opSelW;
  logic                loadUse;

  // Load in execute feeding the instruction in decode.
  assign loadUse = idExMemRd && idExRegWe && (idExRd != '0) &&
                   ((idExRd == ifIdRs1) || (idExRd == ifIdRs2));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_fwd_pick #(.AW(AW)) i_pick (
      .srcReg     (idExRs[g]),
      .exMemRd    (exMemRd),
      .exMemRegWe (exMemRegWe),
      .memWbRd    (memWbRd),
      .memWbRegWe (memWbRegWe),
      .sel        (opSelW[g])
    );

    // R6: register 0 never feeds an operand from a pipeline stage
    p_zero_not_forwarded_r6 : assert property (@(posedge clk) disable iff (!rstN)
      (opSelW[g] != SRC_RF) |-> (idExRs[g] != '0));

    // R7: writeback path is never chosen while the memory stage also matches
    p_younger_wins_r7 : assert property (@(posedge clk) disable iff (!rstN)
      (opSelW[g] == SRC_WB) |-> !(exMemRegWe && (exMemRd == idExRs[g])));

    p_sel_encoding_r3 : assert property (@(posedge clk) disable iff (!rstN)
      opSelW[g] != opSrcE'(2'b11));
  end

  always_comb begin
    strobes.holdFront    = loadUse;
    strobes.injectBubble = loadUse;
    strobes.opSel        = opSelW;
  end

  // R4: the interlock never lasts two cycles in a row
  p_single_stall_r4 : assert property (@(posedge clk) disable iff (!rstN)
    loadUse |=> !loadUse);
endmodule

// File: rtl/hzd_pipe.sv
module hzd_pipe
  import hzd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 5,
  parameter int PC_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobesT                strobes,
  input  logic [AW-1:0]              fetchRs1,
  input  logic [AW-1:0]              fetchRs2,
  input  logic [AW-1:0]              fetchRd,
  input  logic                       fetchRegWe,
  input  logic                       fetchMemRd,
  input  logic                       fetchMemWe,
  input  logic [DW-1:0]              rfData1,
  input  logic [DW-1:0]              rfData2,
  input  logic [DW-1:0]              exAluResult,
  input  logic [DW-1:0]              memRdData,
  output logic [PC_W-1:0]            pcOut,
  output logic [AW-1:0]              ifIdRs1,
  output logic [AW-1:0]              ifIdRs2,
  output logic [NUM_SRC-1:0][AW-1:0] idExRs,
  output logic [AW-1:0]              idExRd,
  output logic                       idExRegWe,
  output logic                       idExMemRd,
  output logic [AW-1:0]              exMemRd,
  output logic                       exMemRegWe,
  output logic [AW-1:0]              memWbRd,
  output logic                       memWbRegWe,
  output logic [DW-1:0]              aluOpA,
  output logic [DW-1:0]              aluOpB,
  output logic                       memWeOut,
  output logic [DW-1:0]              wbData
);
  logic [AW-1:0]              ifIdRd;
  logic                       ifIdRegWe, ifIdMemRd, ifIdMemWe;
  logic                       idExMemWe;
  logic [NUM_SRC-1:0][DW-1:0] idExVal;
  logic                       exMemMemRd, exMemMemWe;
  logic [DW-1:0]              exMemAlu;
  logic [NUM_SRC-1:0][DW-1:0] opnd;

  // Front end: program counter and decode register, frozen on a stall.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut     <= '0;
      ifIdRs1   <= '0;
      ifIdRs2   <= '0;
      ifIdRd    <= '0;
      ifIdRegWe <= 1'b0;
      ifIdMemRd <= 1'b0;
      ifIdMemWe <= 1'b0;
    end else if (!strobes.holdFront) begin
      pcOut     <= pcOut + 1'b1;
      ifIdRs1   <= fetchRs1;
      ifIdRs2   <= fetchRs2;
      ifIdRd    <= fetchRd;
      ifIdRegWe <= fetchRegWe;
      ifIdMemRd <= fetchMemRd;
      ifIdMemWe <= fetchMemWe;
    end
  end

  // Execute register: a bubble enters with every field and enable cleared.
  always_ff @(posedge clk) begin
    if (!rstN || strobes.injectBubble) begin
      idExRs    <= '0;
      idExRd    <= '0;
      idExRegWe <= 1'b0;
      idExMemRd <= 1'b0;
      idExMemWe <= 1'b0;
      idExVal   <= '0;
    end else begin
      idExRs[0]  <= ifIdRs1;
      idExRs[1]  <= ifIdRs2;
      idExRd     <= ifIdRd;
      idExRegWe  <= ifIdRegWe;
      idExMemRd  <= ifIdMemRd;
      idExMemWe  <= ifIdMemWe;
      idExVal[0] <= rfData1;
      idExVal[1] <= rfData2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exMemRd    <= '0;
      exMemRegWe <= 1'b0;
      exMemMemRd <= 1'b0;
      exMemMemWe <= 1'b0;
      exMemAlu   <= '0;
      memWbRd    <= '0;
      memWbRegWe <= 1'b0;
      wbData     <= '0;
    end else begin
      exMemRd    <= idExRd;
      exMemRegWe <= idExRegWe;
      exMemMemRd <= idExMemRd;
      exMemMemWe <= idExMemWe;
      exMemAlu   <= exAluResult;
      memWbRd    <= exMemRd;
      memWbRegWe <= exMemRegWe;
      wbData     <= exMemMemRd ? memRdData : exMemAlu;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    logic [DW-1:0] pick;
    always_comb begin
      unique case (strobes.opSel[g])
        SRC_MEM: pick = exMemAlu;
        SRC_WB:  pick = wbData;
        default: pick = idExVal[g];
      endcase
    end
    assign opnd[g] = pick;
  end

  assign aluOpA   = opnd[0];
  assign aluOpB   = opnd[1];
  assign memWeOut = exMemMemWe;

  // R5: the slot loaded after a bubble request carries no write enable
  p_bubble_silent_r5 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.injectBubble |=> (!idExRegWe && !idExMemWe));

  // R8: the front end keeps its state across a stall
  p_front_frozen_r8 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdFront |=> ((pcOut == $past(pcOut)) && (ifIdRs1 == $past(ifIdRs1))
                           && (ifIdRs2 == $past(ifIdRs2))));
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import hzd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 5,
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   fetchRs1,
  input  logic [AW-1:0]   fetchRs2,
  input  logic [AW-1:0]   fetchRd,
  input  logic            fetchRegWe,
  input  logic            fetchMemRd,
  input  logic            fetchMemWe,
  output logic [PC_W-1:0] pcOut,
  input  logic [DW-1:0]   rfData1,
  input  logic [DW-1:0]   rfData2,
  input  logic [DW-1:0]   exAluResult,
  input  logic [DW-1:0]   memRdData,
  output logic [DW-1:0]   aluOpA,
  output logic [DW-1:0]   aluOpB,
  output logic [1:0]      fwdSelA,
  output logic [1:0]      fwdSelB,
  output logic            stallFetch,
  output logic            bubbleInsert,
  output logic            memWeOut,
  output logic            wbWe,
  output logic [AW-1:0]   wbRd,
  output logic [DW-1:0]   wbData
);
  ctrlStrobesT                strobes;
  logic [AW-1:0]              ifIdRs1, ifIdRs2;
  logic [NUM_SRC-1:0][AW-1:0] idExRs;
  logic [AW-1:0]              idExRd, exMemRd;
  logic                       idExRegWe, idExMemRd, exMemRegWe;

  hzd_ctrl #(.AW(AW)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ifIdRs1    (ifIdRs1),
    .ifIdRs2    (ifIdRs2),
    .idExRs     (idExRs),
    .idExRd     (idExRd),
    .idExRegWe  (idExRegWe),
    .idExMemRd  (idExMemRd),
    .exMemRd    (exMemRd),
    .exMemRegWe (exMemRegWe),
    .memWbRd    (wbRd),
    .memWbRegWe (wbWe),
    .strobes    (strobes)
  );

  hzd_pipe #(.DW(DW), .AW(AW), .PC_W(PC_W)) i_pipe (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .fetchRs1    (fetchRs1),
    .fetchRs2    (fetchRs2),
    .fetchRd     (fetchRd),
    .fetchRegWe  (fetchRegWe),
    .fetchMemRd  (fetchMemRd),
    .fetchMemWe  (fetchMemWe),
    .rfData1     (rfData1),
    .rfData2     (rfData2),
    .exAluResult (exAluResult),
    .memRdData   (memRdData),
    .pcOut       (pcOut),
    .ifIdRs1     (ifIdRs1),
    .ifIdRs2     (ifIdRs2),
    .idExRs      (idExRs),
    .idExRd      (idExRd),
    .idExRegWe   (idExRegWe),
    .idExMemRd   (idExMemRd),
    .exMemRd     (exMemRd),
    .exMemRegWe  (exMemRegWe),
    .memWbRd     (wbRd),
    .memWbRegWe  (wbWe),
    .aluOpA      (aluOpA),
    .aluOpB      (aluOpB),
    .memWeOut    (memWeOut),
    .wbData      (wbData)
  );

  assign fwdSelA      = strobes.opSel[0];
  assign fwdSelB      = strobes.opSel[1];
  assign stallFetch   = strobes.holdFront;
  assign bubbleInsert = strobes.injectBubble;
endmodule

// File: tb/test_fwd_interlock_unit.sv
module test_fwd_interlock_unit;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam int PC_W = 8;
  localparam logic [DW-1:0] RF_A = 16'h0A0A;
  localparam logic [DW-1:0] RF_B = 16'h0B0B;
  localparam logic [DW-1:0] LOAD_VAL = 16'h5A5A;

  typedef struct packed {
    logic [AW-1:0] rs1, rs2, rd;
    logic we, ld, st;
  } instT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  instT prog [16];
  instT cur;
  logic [PC_W-1:0] pcOut;
  logic [DW-1:0] aluOpA, aluOpB, wbData, exAluResult;
  logic [1:0] fwdSelA, fwdSelB;
  logic stallFetch, bubbleInsert, memWeOut, wbWe;
  logic [AW-1:0] wbRd;

  int compared = 0;
  int mismatched = 0;

  // Sampled results of one program run
  int stallCnt, wbCnt, memCnt;
  logic [1:0] sSelA, sSelB;
  logic [DW-1:0] sOpA, sOpB;
  logic [PC_W-1:0] pcLog [32];

  always #2 clk = ~clk;  // 250 MHz

  assign cur = prog[pcOut[3:0]];
  assign exAluResult = {8'hE0, pcOut};  // ALU model: tag of the execute slot

  fwd_interlock_unit #(.DW(DW), .AW(AW), .PC_W(PC_W)) i_fwd_interlock_unit (
    .clk(clk), .rstN(rstN),
    .fetchRs1(cur.rs1), .fetchRs2(cur.rs2), .fetchRd(cur.rd),
    .fetchRegWe(cur.we), .fetchMemRd(cur.ld), .fetchMemWe(cur.st),
    .pcOut(pcOut), .rfData1(RF_A), .rfData2(RF_B),
    .exAluResult(exAluResult), .memRdData(LOAD_VAL),
    .aluOpA(aluOpA), .aluOpB(aluOpB), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallFetch(stallFetch), .bubbleInsert(bubbleInsert), .memWeOut(memWeOut),
    .wbWe(wbWe), .wbRd(wbRd), .wbData(wbData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = '0;
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic runProg(input int sampleEdge, input int lastEdge);
    stallCnt = 0; wbCnt = 0; memCnt = 0;
    sSelA = '0; sSelB = '0; sOpA = '0; sOpB = '0;
    doReset();
    for (int e = 1; e <= lastEdge; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (stallFetch) stallCnt++;
      if (wbWe) wbCnt++;
      if (memWeOut) memCnt++;
      if (e < 32) pcLog[e] = pcOut;
      if (e == sampleEdge) begin
        sSelA = fwdSelA; sSelB = fwdSelB; sOpA = aluOpA; sOpB = aluOpB;
      end
    end
  endtask

  function automatic string selTag(input int expSel, input bit stalled, input int kind,
                                   input int rd, input int rs);
    if (expSel == 2) return "R1";
    if (expSel == 1) return stalled ? "R4" : "R2";
    if (rs == rd && rd == 0) return "R6";
    if (rs == rd && kind == 2) return "R9";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    clearProg();
    // R10: reset state
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 pc", 32'(pcOut), 0);
    chk("R10 selA", 32'(fwdSelA), 0);
    chk("R10 selB", 32'(fwdSelB), 0);
    chk("R10 stall", 32'(stallFetch), 0);
    chk("R10 wbWe", 32'(wbWe), 0);
    chk("R10 memWe", 32'(memWeOut), 0);

    // Sweep: producer kind (0 alu, 1 load, 2 no write), destination, gap, sources
    for (int kind = 0; kind < 3; kind++)
      for (int rd = 0; rd < 4; rd++)
        for (int gap = 0; gap < 4; gap++)
          for (int rs1 = 0; rs1 < 4; rs1++)
            for (int rs2 = 0; rs2 < 4; rs2++) begin
              bit m1, m2, stallExp;
              int e1, e2;
              logic [DW-1:0] v1, v2, prodVal;
              clearProg();
              prog[0].rd = AW'(rd);
              prog[0].we = (kind != 2);
              prog[0].ld = (kind == 1);
              prog[gap+1].rs1 = AW'(rs1);
              prog[gap+1].rs2 = AW'(rs2);
              m1 = (kind != 2) && (rd != 0) && (rs1 == rd);
              m2 = (kind != 2) && (rd != 0) && (rs2 == rd);
              stallExp = (kind == 1) && (gap == 0) && (m1 || m2);
              e1 = !m1 ? 0 : (gap == 0 && !stallExp) ? 2 : (gap <= 1) ? 1 : 0;
              e2 = !m2 ? 0 : (gap == 0 && !stallExp) ? 2 : (gap <= 1) ? 1 : 0;
              prodVal = (kind == 1) ? LOAD_VAL : 16'hE002;
              v1 = (e1 == 2) ? 16'hE002 : (e1 == 1) ? prodVal : RF_A;
              v2 = (e2 == 2) ? 16'hE002 : (e2 == 1) ? prodVal : RF_B;
              runProg(gap + 3 + int'(stallExp), gap + 7 + int'(stallExp));
              chk(selTag(e1, stallExp, kind, rd, rs1), 32'(sSelA), 32'(e1));
              chk(selTag(e2, stallExp, kind, rd, rs2), 32'(sSelB), 32'(e2));
              chk(selTag(e1, stallExp, kind, rd, rs1), 32'(sOpA), 32'(v1));
              chk(selTag(e2, stallExp, kind, rd, rs2), 32'(sOpB), 32'(v2));
              chk(stallExp ? "R4 stall count" : (rd == 0 ? "R6 stall count" :
                  (kind == 2 ? "R9 stall count" : "R4 stall count")),
                  32'(stallCnt), stallExp ? 1 : 0);
              chk("R5 write count", 32'(wbCnt), (kind != 2) ? 1 : 0);
            end

    // R7: two producers of register 1, consumer reads it on both sources
    clearProg();
    prog[0].rd = 2'd1; prog[0].we = 1'b1;
    prog[1].rd = 2'd1; prog[1].we = 1'b1;
    prog[2].rs1 = 2'd1; prog[2].rs2 = 2'd1;
    runProg(4, 8);
    chk("R7 selA", 32'(sSelA), 2);
    chk("R7 opA", 32'(sOpA), 32'h0000E003);
    chk("R7 opB", 32'(sOpB), 32'h0000E003);

    // R4/R5/R8: load, dependent add, then store of the loaded register
    clearProg();
    prog[0].rd = 2'd2; prog[0].we = 1'b1; prog[0].ld = 1'b1;
    prog[1].rs1 = 2'd2; prog[1].rd = 2'd3; prog[1].we = 1'b1;
    prog[2].rs2 = 2'd2; prog[2].st = 1'b1;
    runProg(4, 10);
    chk("R4 stall cycles", 32'(stallCnt), 1);
    chk("R4 loaded operand", 32'(sOpA), 32'(LOAD_VAL));
    chk("R4 select after bubble", 32'(sSelA), 1);
    chk("R5 register writes", 32'(wbCnt), 2);
    chk("R5 memory writes", 32'(memCnt), 1);
    chk("R8 pc step", 32'(pcLog[1]), 1);
    chk("R8 pc before stall", 32'(pcLog[2]), 2);
    chk("R8 pc held", 32'(pcLog[3]), 2);
    chk("R8 pc resumes", 32'(pcLog[4]), 3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule